// File: doc/BRIEF.md
# Clock Reference Mode Controller

This block is the control state machine of a synchronizing clock unit. On every clock it picks one of four operating conditions for the oscillator loop: Free Run, Lock to Reference A, Lock to Reference B or Hold Last. It reports that choice on a two-bit status output. In manual operation the status simply copies the user's control code. In the two autonomous operations the controller checks whether each reference is qualified and whether a held loop value exists, and it overrides the user's request when that request cannot be honoured safely.

Each reference has its own qualification timer. The timer counts one-second ticks while the reference's presence flag stays high, and the reference counts as qualified once `QUAL_SEC` ticks have been counted. A loss-of-lock alarm raised while the loop is locked restarts the timer of the reference in use. While the loop is locked and not alarmed, each tick produces a one-cycle latch-enable pulse for the external hold register. The first such pulse sets a sticky hold-valid flag.

Top module: `clkref_mode_ctrl`

## Requirements
- R1: `mode_sel_i[1]`=0 selects manual operation and `mode_sel_i[0]` is then ignored. `mode_sel_i`=2'b10 selects autonomous non-revertive operation and 2'b11 selects autonomous revertive operation.
- R2: `ctl_req_i` and `ctl_status_o` use one code: 2'b00 is Free Run, 2'b01 is Lock to A, 2'b10 is Lock to B and 2'b11 is Hold Last.
- R3: In manual operation, `ctl_status_o` equals the `ctl_req_i` value of the previous clock. Reference qualification and the hold-valid flag have no effect on it.
- R4: In autonomous operation, when the requested reference is unqualified and the other reference is qualified, the status locks to the other reference.
- R5: In autonomous operation with neither reference qualified, the status goes to Hold Last if `hold_valid_o` is 1 and to Free Run otherwise. Hold Last is never reached autonomously while `hold_valid_o` is 0.
- R6: In revertive operation, the status moves to the requested (preferred) reference as soon as that reference is qualified, even while another qualified reference is in use.
- R7: In non-revertive operation, the status stays on the reference in use for as long as that reference remains qualified, whatever reference is requested.
- R8: A reference becomes qualified only after `QUAL_SEC` ticks of `sec_tick_i` (default 10) with its presence flag held high. A low presence flag clears its count at once.
- R9: `lol_i` high while the status locks to a reference clears that reference's qualification count. Restart takes priority over a tick in the same cycle.
- R10: `hold_load_o` is high for one clock, in the clock after a `sec_tick_i` sampled while the status is Lock to A or B with `lol_i` low, and at no other time. `hold_valid_o` rises with the first such pulse and then stays high.
- R11: While `rst` is high, and after it is released, the status is Free Run, `hold_valid_o` is 0, `hold_load_o` is 0 and both qualification counts are zero.
- R12: A change of the chosen condition appears on `ctl_status_o` exactly one clock after the inputs that cause it are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal state-machine clock |
| rst | input | 1 | Synchronous module reset to power-on condition, active high |
| mode_sel_i | input | 2 | Operation select: manual, autonomous non-revertive, autonomous revertive |
| ctl_req_i | input | 2 | Requested operating condition |
| ref_a_live_i | input | 1 | Reference A signal present |
| ref_b_live_i | input | 1 | Reference B signal present |
| lol_i | input | 1 | Loss-of-lock alarm of the active reference |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| ctl_status_o | output | 2 | Current operating condition |
| hold_valid_o | output | 1 | A held loop value has been captured |
| hold_load_o | output | 1 | Latch enable for the external hold register |

## Verification
The one-second tick and the loss-of-lock alarm can arrive in the same clock while the loop is locked. That clock decides two things at once: whether a hold capture happens, and whether the active reference's count advances or restarts. The bench drives both in one clock while the loop is locked to B. It then expects `hold_load_o` to stay low in the next clock, and it expects the status to fall to Hold Last once B has lost qualification and A has not yet requalified. Reset is also asserted while both references are present, to check that qualification has to start again from zero.

// File: rtl/clkref_pkg.sv
package clkref_pkg;

   typedef enum logic [1:0] {
      CS_FREE   = 2'b00,
      CS_LOCK_A = 2'b01,
      CS_LOCK_B = 2'b10,
      CS_HOLD   = 2'b11
   } cs_e;

   typedef enum logic [1:0] {
      OPM_MANUAL  = 2'b00,
      OPM_AUTO_NR = 2'b01,
      OPM_AUTO_RV = 2'b10
   } opm_e;

   function automatic opm_e decode_opm(input logic [1:0] sel);
      if (!sel[1])
         return OPM_MANUAL;
      else if (sel[0])
         return OPM_AUTO_RV;
      else
         return OPM_AUTO_NR;
   endfunction

   function automatic logic is_lock(input cs_e s);
      return (s == CS_LOCK_A) || (s == CS_LOCK_B);
   endfunction

endpackage

// File: rtl/clkref_qual_timer.sv
module clkref_qual_timer #(
   parameter int QUAL_SEC = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic present_i,
   input  logic restart_i,
   input  logic tick_i,
   output logic valid_o
);
   localparam int CW = $clog2(QUAL_SEC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(QUAL_SEC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !present_i || restart_i)
         cnt_q <= '0;
      else if (tick_i && cnt_q != LIMIT)
         cnt_q <= cnt_q + CW'(1);
   end

   assign valid_o = (cnt_q == LIMIT);

endmodule

// File: rtl/clkref_hold_track.sv
module clkref_hold_track #(
   parameter bit LOAD_REG = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic locked_i,
   input  logic lol_i,
   output logic hold_load_o,
   output logic hold_valid_o
);
   logic capture;
   logic hv_q;

   assign capture = tick_i && locked_i && !lol_i;

   always_ff @(posedge clk) begin
      if (rst)
         hv_q <= 1'b0;
      else if (capture)
         hv_q <= 1'b1;
   end
   assign hold_valid_o = hv_q;

   generate
      if (LOAD_REG) begin : g_load_reg
         logic ld_q;
         always_ff @(posedge clk) begin
            if (rst)
               ld_q <= 1'b0;
            else
               ld_q <= capture;
         end
         assign hold_load_o = ld_q;
      end else begin : g_load_comb
         assign hold_load_o = capture && !rst;
      end
   endgenerate

endmodule

// File: rtl/clkref_mode_fsm.sv
module clkref_mode_fsm
   import clkref_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  opm_e       opm_i,
   input  cs_e        req_i,
   input  logic [1:0] ref_ok_i,
   input  logic       hlv_i,
   output cs_e        state_o
);
   cs_e state_q;
   cs_e nxt;
   logic cur_ok;
   logic pref_b;
   logic pref_ok;
   logic oth_ok;
   cs_e  oth;
   cs_e  fallback;

   always_comb begin
      cur_ok   = ((state_q == CS_LOCK_A) && ref_ok_i[0]) ||
                 ((state_q == CS_LOCK_B) && ref_ok_i[1]);
      fallback = hlv_i ? CS_HOLD : CS_FREE;
      pref_b   = (req_i == CS_LOCK_B);
      pref_ok  = pref_b ? ref_ok_i[1] : ref_ok_i[0];
      oth_ok   = pref_b ? ref_ok_i[0] : ref_ok_i[1];
      oth      = pref_b ? CS_LOCK_A : CS_LOCK_B;
      nxt      = state_q;
      if (opm_i == OPM_MANUAL) begin
         nxt = req_i;
      end else begin
         case (req_i)
            CS_FREE: nxt = CS_FREE;
            CS_HOLD: begin
               if (hlv_i)
                  nxt = CS_HOLD;
               else if (cur_ok)
                  nxt = state_q;
               else
                  nxt = CS_FREE;
            end
            default: begin
               if (opm_i == OPM_AUTO_NR && cur_ok)
                  nxt = state_q;
               else if (pref_ok)
                  nxt = req_i;
               else if (oth_ok)
                  nxt = oth;
               else
                  nxt = fallback;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= CS_FREE;
      else
         state_q <= nxt;
   end

   assign state_o = state_q;

endmodule

// File: rtl/clkref_mode_ctrl.sv
module clkref_mode_ctrl
   import clkref_pkg::*;
#(
   parameter int QUAL_SEC = 10,
   parameter bit LOAD_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] mode_sel_i,
   input  logic [1:0] ctl_req_i,
   input  logic       ref_a_live_i,
   input  logic       ref_b_live_i,
   input  logic       lol_i,
   input  logic       sec_tick_i,
   output logic [1:0] ctl_status_o,
   output logic       hold_valid_o,
   output logic       hold_load_o
);
   localparam int NREF = 2;

   generate
      if (QUAL_SEC < 1 || QUAL_SEC > 65535) begin : g_bad_qual
         $error("QUAL_SEC must lie in 1..65535");
      end
   endgenerate

   cs_e              state;
   logic [NREF-1:0]  ref_live;
   logic [NREF-1:0]  ref_qual;
   logic             hlv;

   assign ref_live = {ref_b_live_i, ref_a_live_i};

   generate
      for (genvar i = 0; i < NREF; i++) begin : g_ref
         localparam cs_e OWN_LOCK = (i == 0) ? CS_LOCK_A : CS_LOCK_B;
         clkref_qual_timer #(.QUAL_SEC(QUAL_SEC)) u_qual (
            .clk       (clk),
            .rst       (rst),
            .present_i (ref_live[i]),
            .restart_i (lol_i && (state == OWN_LOCK)),
            .tick_i    (sec_tick_i),
            .valid_o   (ref_qual[i])
         );
      end
   endgenerate

   clkref_mode_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .opm_i    (decode_opm(mode_sel_i)),
      .req_i    (cs_e'(ctl_req_i)),
      .ref_ok_i (ref_qual),
      .hlv_i    (hlv),
      .state_o  (state)
   );

   clkref_hold_track #(.LOAD_REG(LOAD_REG)) u_hold (
      .clk          (clk),
      .rst          (rst),
      .tick_i       (sec_tick_i),
      .locked_i     (is_lock(state)),
      .lol_i        (lol_i),
      .hold_load_o  (hold_load_o),
      .hold_valid_o (hlv)
   );

   assign ctl_status_o = state;
   assign hold_valid_o = hlv;

endmodule

// File: rtl/clkref_mode_ctrl_chk.sv
module clkref_mode_ctrl_chk (
   input logic       clk,
   input logic       rst,
   input logic [1:0] mode_sel_i,
   input logic [1:0] ctl_req_i,
   input logic       sec_tick_i,
   input logic [1:0] ref_qual,
   input logic [1:0] ctl_status_o,
   input logic       hold_valid_o,
   input logic       hold_load_o
);
   // R3 / R12: manual status copies the previous request
   a_r3_manual_follows: assert property (@(posedge clk) disable iff (rst)
      !mode_sel_i[1] |=> ctl_status_o == $past(ctl_req_i));

   // R4: requested B unqualified, A qualified -> lock A
   a_r4_take_other: assert property (@(posedge clk) disable iff (rst)
      (mode_sel_i[1] && ctl_req_i == 2'b10 && !ref_qual[1] && ref_qual[0])
      |=> ctl_status_o == 2'b01);

   // R5: no autonomous Hold Last without a held value
   a_r5_no_hold_without_hlv: assert property (@(posedge clk) disable iff (rst)
      (mode_sel_i[1] && !hold_valid_o) |=> ctl_status_o != 2'b11);

   // R10: load pulse follows a tick and sets the valid flag
   a_r10_load_after_tick: assert property (@(posedge clk) disable iff (rst)
      hold_load_o |-> $past(sec_tick_i));

   a_r10_load_sets_valid: assert property (@(posedge clk) disable iff (rst)
      hold_load_o |=> hold_valid_o);

   a_r10_valid_sticky: assert property (@(posedge clk) disable iff (rst)
      hold_valid_o |=> hold_valid_o);

   // R11: reset returns to power-on condition
   a_r11_reset_state: assert property (@(posedge clk)
      rst |=> (ctl_status_o == 2'b00 && !hold_valid_o && ref_qual == 2'b00));

endmodule

bind clkref_mode_ctrl clkref_mode_ctrl_chk u_chk (.*);

// File: tb/sim_clkref_mode_ctrl.sv
module sim_clkref_mode_ctrl;
   localparam time CLK_PERIOD = 10ns;
   localparam int  QS = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] mode_sel = 2'b00;
   logic [1:0] ctl_req = 2'b00;
   logic       ref_a = 1'b0;
   logic       ref_b = 1'b0;
   logic       lol = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] cs;
   logic       hlv;
   logic       hload;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clkref_mode_ctrl #(.QUAL_SEC(QS)) u0 (
      .clk(clk), .rst(rst), .mode_sel_i(mode_sel), .ctl_req_i(ctl_req),
      .ref_a_live_i(ref_a), .ref_b_live_i(ref_b), .lol_i(lol),
      .sec_tick_i(tick), .ctl_status_o(cs), .hold_valid_o(hlv),
      .hold_load_o(hload)
   );

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      rst = 1'b1;
      step(2);
      chk("R11 status", cs, 2'b00);
      chk("R11 hlv", {1'b0, hlv}, 2'b00);
      chk("R11 load", {1'b0, hload}, 2'b00);
      rst = 1'b0;
      step(1);
   endtask

   task automatic t_manual;
      mode_sel = 2'b00;
      ctl_req = 2'b11;
      step(1);
      chk("R3 R12 manual hold without hlv", cs, 2'b11);
      ctl_req = 2'b01;
      step(1);
      chk("R3 R12 manual lock A unqualified", cs, 2'b01);
      mode_sel = 2'b01;
      ctl_req = 2'b10;
      step(1);
      chk("R1 R2 mode bit0 ignored in manual", cs, 2'b10);
   endtask

   task automatic t_qualify;
      mode_sel = 2'b10;
      ctl_req = 2'b01;
      ref_a = 1'b1;
      step(2);
      chk("R5 no refs no hlv -> free", cs, 2'b00);
      ticks(QS - 1);
      step(2);
      chk("R8 not yet qualified", cs, 2'b00);
      chk("R10 no load outside lock", {1'b0, hload}, 2'b00);
      ticks(1);
      step(2);
      chk("R8 qualified -> lock A", cs, 2'b01);
      chk("R10 hlv still clear", {1'b0, hlv}, 2'b00);
      tick = 1'b1;
      step(1);
      tick = 1'b0;
      chk("R10 load pulse", {1'b0, hload}, 2'b01);
      chk("R10 hlv set", {1'b0, hlv}, 2'b01);
      step(1);
      chk("R10 load one clock", {1'b0, hload}, 2'b00);
   endtask

   task automatic t_holdover;
      ref_a = 1'b0;
      step(3);
      chk("R5 no refs with hlv -> hold", cs, 2'b11);
   endtask

   task automatic t_override;
      ref_b = 1'b1;
      ticks(QS);
      step(2);
      chk("R4 A requested invalid -> B", cs, 2'b10);
      ref_a = 1'b1;
      ticks(QS);
      step(2);
      chk("R7 non-revertive stays on B", cs, 2'b10);
      mode_sel = 2'b11;
      step(1);
      chk("R6 revertive returns to A", cs, 2'b01);
   endtask

   task automatic t_lol;
      lol = 1'b1;
      step(1);
      lol = 1'b0;
      step(2);
      chk("R9 lol drops A -> B", cs, 2'b10);
      lol = 1'b1;
      tick = 1'b1;
      step(1);
      lol = 1'b0;
      tick = 1'b0;
      chk("R10 tick with lol no load", {1'b0, hload}, 2'b00);
      step(2);
      chk("R9 lol restart beats tick -> hold", cs, 2'b11);
      chk("R10 hlv stays set", {1'b0, hlv}, 2'b01);
   endtask

   task automatic t_reset_mid;
      rst = 1'b1;
      step(2);
      chk("R11 reset mid-run status", cs, 2'b00);
      chk("R11 reset mid-run hlv", {1'b0, hlv}, 2'b00);
      rst = 1'b0;
      mode_sel = 2'b11;
      ctl_req = 2'b01;
      step(3);
      chk("R11 timers cleared", cs, 2'b00);
      ctl_req = 2'b11;
      step(2);
      chk("R5 hold request without hlv -> free", cs, 2'b00);
   endtask

   initial begin
      t_reset();
      t_manual();
      t_qualify();
      t_holdover();
      t_override();
      t_lol();
      t_reset_mid();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule